// File: doc/BRIEF.md
# Interrupt Flag and Mask Register Block

This block sits between the core of a serial bus controller and the register port of its host. It captures what the core reports and holds it for software to read. Single-cycle pulses from the core mark events such as a lost arbitration, a missing acknowledge or an overrun. Level inputs signal that data is waiting to be moved in or out. A live bus-busy level from the core is also shown.

Software reads the status word, masks it through an enable word and clears flags by writing ones. One level-sensitive interrupt line is high whenever any stored flag is set with its enable bit also set. A data-ready flag cannot be lost by an early acknowledge. While its condition persists it stays set, and after the condition ends it holds until software clears it.

The register port is a plain word-wide port. A write takes effect at the clock edge on which `reg_wen` is sampled high. Reads are combinational from `reg_addr` and have no side effects. There is no back-pressure: every access completes in the cycle it is presented.

Top module: `irq_regs`

## Requirements
- R1: A synchronous active-high `rst` clears every stored status bit and every enable bit. While `rst` is high and in the first cycle after it, the enable word reads 0x0000, the status word reads zero apart from bit 12 (which follows `bus_busy`), and `irq_o` is low.
- R2: A write to byte offset 0x04 loads the enable word with `reg_wdata & 0x601F`. Only bits 0–4, 13 and 14 are enableable; the other positions read back as zero.
- R3: A one-cycle pulse sets a sticky status bit at the next clock edge, at these positions: `evt_arb_lost` bit 0, `evt_nack` bit 1, `evt_acc_rdy` bit 2, `evt_addr_zero` bit 8, `evt_slave_hit` bit 9, `evt_tx_underflow` bit 10 and `evt_rx_overrun` bit 11. The bit stays set after the pulse.
- R4: A write to offset 0x08 clears each stored status bit whose `reg_wdata` bit is 1 and leaves bits written with 0 unchanged, so several flags can be cleared in one write.
- R5: When a set pulse and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R6: The condition inputs set these bits: `cond_rx_rdy` bit 3, `cond_tx_rdy` bit 4, `cond_rx_drain` bit 13 and `cond_tx_drain` bit 14. The bit is set in every cycle after a cycle in which its condition is high. A clearing write has no effect while the condition is high. After the condition falls, the bit holds until it is cleared.
- R7: Status bit 12 reads the live value of `bus_busy` in the same cycle. Writing 1 to bit 12 does not change it.
- R8: `irq_o` is high exactly when some stored status bit and its enable bit are both 1. Status bits 8 to 11 never raise `irq_o`.
- R9: Status bits 5, 6, 7 and 15 always read zero. Any offset other than 0x04 and 0x08 reads 0x0000, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W | Byte offset of the register accessed |
| reg_wen | input | 1 | Write strobe, sampled at the clock edge |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| evt_arb_lost | input | 1 | Pulse: arbitration lost |
| evt_nack | input | 1 | Pulse: no acknowledge received |
| evt_acc_rdy | input | 1 | Pulse: register access ready |
| evt_addr_zero | input | 1 | Pulse: general-call address seen |
| evt_slave_hit | input | 1 | Pulse: addressed as a target |
| evt_tx_underflow | input | 1 | Pulse: transmit underflow |
| evt_rx_overrun | input | 1 | Pulse: receive overrun |
| cond_rx_rdy | input | 1 | Level: receive data waiting |
| cond_tx_rdy | input | 1 | Level: transmit space waiting |
| cond_rx_drain | input | 1 | Level: receive buffer draining |
| cond_tx_drain | input | 1 | Level: transmit buffer draining |
| bus_busy | input | 1 | Level: bus busy, shown live |
| irq_o | output | 1 | Level-sensitive interrupt request |

## Verification
Directed sequences try the block with several input patterns:
- Single and grouped event pulses, which separate a correct bit placement from a swapped one.
- Partial clearing writes, which tell write-one-to-clear apart from plain loading.
- A pulse and a clear landing on the same bit, which exposes the wrong set/clear priority.
- A condition held across a clear and then dropped, which distinguishes a re-asserting flag from a plain sticky one.
- Non-enableable and unmapped positions, which show that those bits stay zero.
- A bus-busy toggle under a clearing write.

A long run of random pulses, conditions, writes and addresses then checks the status word, the enable word and `irq_o` against a behavioural model on every clock.

// File: rtl/irq_regs_pkg.sv
package irq_regs_pkg;
  localparam int REG_W = 16;

  // bit positions that neighbours and software decode
  localparam int POS_ARB_LOST  = 0;
  localparam int POS_NACK      = 1;
  localparam int POS_ACC_RDY   = 2;
  localparam int POS_RX_RDY    = 3;
  localparam int POS_TX_RDY    = 4;
  localparam int POS_ADDR_ZERO = 8;
  localparam int POS_SLAVE_HIT = 9;
  localparam int POS_TX_UDF    = 10;
  localparam int POS_RX_OVR    = 11;
  localparam int POS_BUSY      = 12;
  localparam int POS_RX_DRAIN  = 13;
  localparam int POS_TX_DRAIN  = 14;

  localparam logic [REG_W-1:0] BIT1 = {{(REG_W-1){1'b0}}, 1'b1};

  localparam logic [REG_W-1:0] EVENT_MASK =
    (BIT1 << POS_ARB_LOST) | (BIT1 << POS_NACK) | (BIT1 << POS_ACC_RDY) |
    (BIT1 << POS_ADDR_ZERO) | (BIT1 << POS_SLAVE_HIT) |
    (BIT1 << POS_TX_UDF) | (BIT1 << POS_RX_OVR);

  localparam logic [REG_W-1:0] COND_MASK =
    (BIT1 << POS_RX_RDY) | (BIT1 << POS_TX_RDY) |
    (BIT1 << POS_RX_DRAIN) | (BIT1 << POS_TX_DRAIN);

  localparam logic [REG_W-1:0] STORE_MASK = EVENT_MASK | COND_MASK;
  localparam logic [REG_W-1:0] BUSY_BIT   = BIT1 << POS_BUSY;

  localparam logic [REG_W-1:0] ENABLE_MASK =
    (BIT1 << POS_ARB_LOST) | (BIT1 << POS_NACK) | (BIT1 << POS_ACC_RDY) |
    (BIT1 << POS_RX_RDY) | (BIT1 << POS_TX_RDY) |
    (BIT1 << POS_RX_DRAIN) | (BIT1 << POS_TX_DRAIN);

  localparam int          ADDR_W_DEF   = 8;
  localparam logic [7:0]  OFF_ENABLE   = 8'h04;
  localparam logic [7:0]  OFF_STATUS   = 8'h08;

  typedef struct packed {
    logic en_sel;
    logic st_sel;
    logic en_wr;
    logic st_wr;
  } reg_sel_t;
endpackage

// File: rtl/irq_addr_dec.sv
module irq_addr_dec
  import irq_regs_pkg::*;
#(
  parameter int ADDR_W = ADDR_W_DEF,
  parameter logic [ADDR_W-1:0] EN_OFF = ADDR_W'(OFF_ENABLE),
  parameter logic [ADDR_W-1:0] ST_OFF = ADDR_W'(OFF_STATUS)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wen,
  output reg_sel_t          sel
);
  always_comb begin
    sel.en_sel = (addr == EN_OFF);
    sel.st_sel = (addr == ST_OFF);
    sel.en_wr  = wen && (addr == EN_OFF);
    sel.st_wr  = wen && (addr == ST_OFF);
  end
endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg
  import irq_regs_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] en_q
);
  always_ff @(posedge clk) begin
    if (rst)     en_q <= '0;
    else if (wr) en_q <= wdata & ENABLE_MASK;
  end
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg
  import irq_regs_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] set_vec,
  input  logic [REG_W-1:0] cond_vec,
  input  logic [REG_W-1:0] clr_vec,
  input  logic             busy,
  output logic [REG_W-1:0] stat_q,
  output logic [REG_W-1:0] stat_rd
);
  logic [REG_W-1:0] clr_eff;
  logic [REG_W-1:0] stat_n;

  always_comb begin
    // a live condition blocks its own acknowledge
    clr_eff = clr_vec & ~cond_vec;
    // setting sources are applied after the clear so they win
    stat_n  = ((stat_q & ~clr_eff) | set_vec | cond_vec) & STORE_MASK;
  end

  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= stat_n;
  end

  assign stat_rd = stat_q | (busy ? BUSY_BIT : '0);
endmodule

// File: rtl/irq_line.sv
module irq_line
  import irq_regs_pkg::*;
(
  input  logic [REG_W-1:0] pend,
  input  logic [REG_W-1:0] en,
  output logic             irq
);
  assign irq = |(pend & en);
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_regs_pkg::*;
#(
  parameter int ADDR_W = ADDR_W_DEF,
  parameter logic [ADDR_W-1:0] EN_OFF = ADDR_W'(OFF_ENABLE),
  parameter logic [ADDR_W-1:0] ST_OFF = ADDR_W'(OFF_STATUS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wen,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              evt_arb_lost,
  input  logic              evt_nack,
  input  logic              evt_acc_rdy,
  input  logic              evt_addr_zero,
  input  logic              evt_slave_hit,
  input  logic              evt_tx_underflow,
  input  logic              evt_rx_overrun,
  input  logic              cond_rx_rdy,
  input  logic              cond_tx_rdy,
  input  logic              cond_rx_drain,
  input  logic              cond_tx_drain,
  input  logic              bus_busy,
  output logic              irq_o
);
  reg_sel_t         sel;
  logic [REG_W-1:0] set_vec;
  logic [REG_W-1:0] cond_vec;
  logic [REG_W-1:0] clr_vec;
  logic [REG_W-1:0] stat_q;
  logic [REG_W-1:0] stat_rd;
  logic [REG_W-1:0] en_q;

  always_comb begin
    set_vec = '0;
    set_vec[POS_ARB_LOST]  = evt_arb_lost;
    set_vec[POS_NACK]      = evt_nack;
    set_vec[POS_ACC_RDY]   = evt_acc_rdy;
    set_vec[POS_ADDR_ZERO] = evt_addr_zero;
    set_vec[POS_SLAVE_HIT] = evt_slave_hit;
    set_vec[POS_TX_UDF]    = evt_tx_underflow;
    set_vec[POS_RX_OVR]    = evt_rx_overrun;
    cond_vec = '0;
    cond_vec[POS_RX_RDY]   = cond_rx_rdy;
    cond_vec[POS_TX_RDY]   = cond_tx_rdy;
    cond_vec[POS_RX_DRAIN] = cond_rx_drain;
    cond_vec[POS_TX_DRAIN] = cond_tx_drain;
  end

  assign clr_vec = sel.st_wr ? reg_wdata : '0;

  irq_addr_dec #(.ADDR_W(ADDR_W), .EN_OFF(EN_OFF), .ST_OFF(ST_OFF)) u_dec (
    .addr (reg_addr),
    .wen  (reg_wen),
    .sel  (sel)
  );

  irq_enable_reg u_en (
    .clk   (clk),
    .rst   (rst),
    .wr    (sel.en_wr),
    .wdata (reg_wdata),
    .en_q  (en_q)
  );

  irq_status_reg u_st (
    .clk      (clk),
    .rst      (rst),
    .set_vec  (set_vec),
    .cond_vec (cond_vec),
    .clr_vec  (clr_vec),
    .busy     (bus_busy),
    .stat_q   (stat_q),
    .stat_rd  (stat_rd)
  );

  irq_line u_irq (
    .pend (stat_q),
    .en   (en_q),
    .irq  (irq_o)
  );

  always_comb begin
    if (sel.en_sel)      reg_rdata = en_q;
    else if (sel.st_sel) reg_rdata = stat_rd;
    else                 reg_rdata = '0;
  end
endmodule

// File: rtl/irq_regs_chk.sv
module irq_regs_chk
  import irq_regs_pkg::*;
#(
  parameter int ADDR_W = ADDR_W_DEF,
  parameter logic [ADDR_W-1:0] EN_OFF = ADDR_W'(OFF_ENABLE),
  parameter logic [ADDR_W-1:0] ST_OFF = ADDR_W'(OFF_STATUS)
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wen,
  input logic [REG_W-1:0]  reg_wdata,
  input logic [REG_W-1:0]  reg_rdata,
  input logic              evt_arb_lost,
  input logic              evt_nack,
  input logic              evt_rx_overrun,
  input logic              cond_tx_rdy,
  input logic              bus_busy,
  input logic              irq_o,
  input logic [REG_W-1:0]  stat_q,
  input logic [REG_W-1:0]  en_q
);
  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (stat_q == '0) && (en_q == '0));

  // R2
  enable_write_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wen && reg_addr == EN_OFF) |=> en_q == ($past(reg_wdata) & ENABLE_MASK));

  // R3
  arb_set_chk: assert property (@(posedge clk) disable iff (rst)
    evt_arb_lost |=> stat_q[POS_ARB_LOST]);

  // R5
  overrun_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_rx_overrun && reg_wen && reg_addr == ST_OFF) |=> stat_q[POS_RX_OVR]);

  // R4
  nack_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wen && reg_addr == ST_OFF && reg_wdata[POS_NACK] && !evt_nack)
      |=> !stat_q[POS_NACK]);

  // R6
  cond_hold_chk: assert property (@(posedge clk) disable iff (rst)
    cond_tx_rdy |=> stat_q[POS_TX_RDY]);

  // R7
  busy_live_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == ST_OFF) |-> reg_rdata[POS_BUSY] == bus_busy);

  // R8
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (en_q != '0) && (stat_q != '0));

  // R9
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_addr != EN_OFF && reg_addr != ST_OFF) |-> reg_rdata == '0);
endmodule

bind irq_regs irq_regs_chk #(.ADDR_W(ADDR_W), .EN_OFF(EN_OFF), .ST_OFF(ST_OFF)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .reg_addr       (reg_addr),
  .reg_wen        (reg_wen),
  .reg_wdata      (reg_wdata),
  .reg_rdata      (reg_rdata),
  .evt_arb_lost   (evt_arb_lost),
  .evt_nack       (evt_nack),
  .evt_rx_overrun (evt_rx_overrun),
  .cond_tx_rdy    (cond_tx_rdy),
  .bus_busy       (bus_busy),
  .irq_o          (irq_o),
  .stat_q         (stat_q),
  .en_q           (en_q)
);

// File: tb/sim_irq_regs.sv
`timescale 1ns/1ps
module sim_irq_regs;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst = 1'b1;
  logic [7:0]  reg_addr = 8'h00;
  logic        reg_wen = 1'b0;
  logic [15:0] reg_wdata = 16'h0000;
  logic [15:0] reg_rdata;
  logic evt_arb_lost = 0, evt_nack = 0, evt_acc_rdy = 0, evt_addr_zero = 0;
  logic evt_slave_hit = 0, evt_tx_underflow = 0, evt_rx_overrun = 0;
  logic cond_rx_rdy = 0, cond_tx_rdy = 0, cond_rx_drain = 0, cond_tx_drain = 0;
  logic bus_busy = 0;
  logic irq_o;

  irq_regs u0 (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wen(reg_wen),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .evt_arb_lost(evt_arb_lost), .evt_nack(evt_nack), .evt_acc_rdy(evt_acc_rdy),
    .evt_addr_zero(evt_addr_zero), .evt_slave_hit(evt_slave_hit),
    .evt_tx_underflow(evt_tx_underflow), .evt_rx_overrun(evt_rx_overrun),
    .cond_rx_rdy(cond_rx_rdy), .cond_tx_rdy(cond_tx_rdy),
    .cond_rx_drain(cond_rx_drain), .cond_tx_drain(cond_tx_drain),
    .bus_busy(bus_busy), .irq_o(irq_o)
  );

  integer checks = 0;
  integer errors = 0;
  bit     done = 0;

  // behavioural reference state
  logic [15:0] m_st = 16'h0000;
  logic [15:0] m_en = 16'h0000;
  logic [15:0] m_set, m_cond, m_clr;

  always @(posedge clk) begin
    if (rst) begin
      m_st = 16'h0000;
      m_en = 16'h0000;
    end else begin
      m_set = 16'h0000;
      if (evt_arb_lost)     m_set[0]  = 1'b1;
      if (evt_nack)         m_set[1]  = 1'b1;
      if (evt_acc_rdy)      m_set[2]  = 1'b1;
      if (evt_addr_zero)    m_set[8]  = 1'b1;
      if (evt_slave_hit)    m_set[9]  = 1'b1;
      if (evt_tx_underflow) m_set[10] = 1'b1;
      if (evt_rx_overrun)   m_set[11] = 1'b1;
      m_cond = 16'h0000;
      if (cond_rx_rdy)   m_cond[3]  = 1'b1;
      if (cond_tx_rdy)   m_cond[4]  = 1'b1;
      if (cond_rx_drain) m_cond[13] = 1'b1;
      if (cond_tx_drain) m_cond[14] = 1'b1;
      m_clr = (reg_wen && reg_addr == 8'h08) ? reg_wdata : 16'h0000;
      for (int b = 0; b < 16; b++) begin
        if (m_set[b] || m_cond[b]) m_st[b] = 1'b1;
        else if (m_clr[b])         m_st[b] = 1'b0;
      end
      if (reg_wen && reg_addr == 8'h04) m_en = reg_wdata & 16'h601F;
    end
  end

  function automatic logic [15:0] m_read(input logic [7:0] a);
    if (a == 8'h04) return m_en;
    if (a == 8'h08) return m_st | (bus_busy ? 16'h1000 : 16'h0000);
    return 16'h0000;
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act %h exp %h", tag, act, exp);
    end
  endtask

  task automatic clear_pulses();
    evt_arb_lost = 0; evt_nack = 0; evt_acc_rdy = 0; evt_addr_zero = 0;
    evt_slave_hit = 0; evt_tx_underflow = 0; evt_rx_overrun = 0;
    reg_wen = 0;
  endtask

  // one clock; compares against the model at negedge + 1ns
  task automatic tick(input string tag);
    @(posedge clk);
    @(negedge clk);
    #1;
    chk({tag, " rdata"}, reg_rdata, m_read(reg_addr));
    chk({tag, " irq"}, {15'd0, irq_o}, {15'd0, |(m_st & m_en)});
    clear_pulses();
  endtask

  task automatic peek(input logic [7:0] a, input string tag, input logic [15:0] exp);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d, input string tag);
    reg_addr = a; reg_wdata = d; reg_wen = 1;
    tick(tag);
  endtask

  initial begin
    #(2_000_000);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog act 0 exp 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    tick("R1 reset");
    rst = 1; reg_addr = 8'h08;
    tick("R1 reset");
    peek(8'h08, "R1 status in reset", 16'h0000);
    peek(8'h04, "R1 enable in reset", 16'h0000);
    chk("R1 irq in reset", {15'd0, irq_o}, 16'h0000);
    rst = 0;
    tick("R1 first cycle");
    peek(8'h08, "R1 status after reset", 16'h0000);

    // R2 enable masking
    wr(8'h04, 16'hFFFF, "R2 write");
    peek(8'h04, "R2 enable readback", 16'h601F);
    wr(8'h04, 16'h0000, "R2 write zero");
    peek(8'h04, "R2 enable zero", 16'h0000);

    // R3 all event pulses at once
    evt_arb_lost = 1; evt_nack = 1; evt_acc_rdy = 1; evt_addr_zero = 1;
    evt_slave_hit = 1; evt_tx_underflow = 1; evt_rx_overrun = 1;
    tick("R3 pulses");
    tick("R3 hold");
    peek(8'h08, "R3 sticky set", 16'h0F07);
    chk("R8 masked irq", {15'd0, irq_o}, 16'h0000);

    // R8 enable gating
    wr(8'h04, 16'h0001, "R8 enable bit0");
    chk("R8 irq on", {15'd0, irq_o}, 16'h0001);
    wr(8'h04, 16'h0F00, "R8 enable non-enableable");
    chk("R8 irq off", {15'd0, irq_o}, 16'h0000);
    peek(8'h04, "R2 enable high bits dropped", 16'h0000);

    // R4 write-one-to-clear
    wr(8'h08, 16'h0003, "R4 clear two");
    peek(8'h08, "R4 after clear", 16'h0F04);
    wr(8'h08, 16'h0000, "R4 write zeros");
    peek(8'h08, "R4 zeros no change", 16'h0F04);

    // R5 set beats clear
    evt_nack = 1;
    wr(8'h08, 16'h0002, "R5 collide");
    peek(8'h08, "R5 set wins", 16'h0F06);

    // R6 condition flags
    cond_rx_rdy = 1;
    tick("R6 cond up");
    peek(8'h08, "R6 ready set", 16'h0F0E);
    wr(8'h08, 16'h0008, "R6 clear while high");
    peek(8'h08, "R6 clear ignored", 16'h0F0E);
    cond_rx_rdy = 0;
    tick("R6 cond down");
    peek(8'h08, "R6 held after drop", 16'h0F0E);
    wr(8'h08, 16'h0008, "R6 clear after drop");
    peek(8'h08, "R6 cleared", 16'h0F06);
    wr(8'h04, 16'h2000, "R6 enable rx drain");
    cond_rx_drain = 1;
    tick("R6 drain up");
    chk("R8 drain irq", {15'd0, irq_o}, 16'h0001);
    peek(8'h08, "R6 drain bit13", 16'h2F06);
    cond_rx_drain = 0;
    wr(8'h08, 16'h2000, "R6 drain clear");
    chk("R8 drain irq off", {15'd0, irq_o}, 16'h0000);

    // R7 bus busy
    bus_busy = 1;
    peek(8'h08, "R7 busy live", 16'h1F06);
    wr(8'h08, 16'h1000, "R7 write busy");
    peek(8'h08, "R7 busy unchanged", 16'h1F06);
    bus_busy = 0;
    peek(8'h08, "R7 busy low", 16'h0F06);

    // R9 undefined bits and offsets
    peek(8'h0C, "R9 unmapped 0C", 16'h0000);
    peek(8'h00, "R9 unmapped 00", 16'h0000);
    wr(8'h0C, 16'hFFFF, "R9 stray write 0C");
    wr(8'h10, 16'hFFFF, "R9 stray write 10");
    peek(8'h08, "R9 status intact", 16'h0F06);
    peek(8'h04, "R9 enable intact", 16'h2000);
    wr(8'h08, 16'hFFFF, "R4 clear all");
    peek(8'h08, "R9 reserved bits zero", 16'h0000);

    // random traffic, model compared every cycle
    for (int i = 0; i < 4000; i++) begin
      evt_arb_lost     = ($urandom % 8) == 0;
      evt_nack         = ($urandom % 8) == 0;
      evt_acc_rdy      = ($urandom % 8) == 0;
      evt_addr_zero    = ($urandom % 8) == 0;
      evt_slave_hit    = ($urandom % 8) == 0;
      evt_tx_underflow = ($urandom % 8) == 0;
      evt_rx_overrun   = ($urandom % 8) == 0;
      if (($urandom % 6) == 0) cond_rx_rdy   = ~cond_rx_rdy;
      if (($urandom % 6) == 0) cond_tx_rdy   = ~cond_tx_rdy;
      if (($urandom % 6) == 0) cond_rx_drain = ~cond_rx_drain;
      if (($urandom % 6) == 0) cond_tx_drain = ~cond_tx_drain;
      if (($urandom % 5) == 0) bus_busy = ~bus_busy;
      case ($urandom % 4)
        0: reg_addr = 8'h04;
        1, 2: reg_addr = 8'h08;
        default: reg_addr = 8'($urandom);
      endcase
      reg_wdata = 16'($urandom);
      reg_wen   = ($urandom % 3) == 0;
      tick("R8 R9 random");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule